// File: doc/BRIEF.md
# Paged RAM Window Address Extender

This block lets an 8-bit processor with a 16-bit address bus reach a 1 MB external RAM through one fixed 256-byte window. The window sits at CPU addresses $D600 to $D6FF and cannot be moved. Two bank registers supply the upper address bits. A page register holds RAM address bits 15..8. A bank register holds RAM address bits 19..16 and a window enable bit. The low eight bits of the CPU address pass straight through. Software therefore moves the window in 256-byte steps by rewriting the page register, and in 64 KB steps by rewriting the bank register.

The block decodes each bus cycle into one of four selections: no target, page register, bank register or window. It drives the RAM chip select, output enable and write enable with no added wait state. The window enable is kept as a two-state mode machine. The states are WIN_OFF and WIN_ON. Reset forces WIN_OFF. A bank-register write with bit 4 set moves the machine to WIN_ON. A bank-register write with bit 4 clear moves it to WIN_OFF. Every other cycle leaves it where it is. The decoder names the selections SEL_NONE, SEL_PAGE, SEL_BANK and SEL_WIN.

Top module: `page_window_ext`

## Requirements
- R1: After reset the page register reads 0x00, the bank register reads 0x00 and the window is disabled.
- R2: A cycle with write strobe and phase high at address $D1E0 loads the page register from the data bus. A write with phase low does not load it. A read at $D1E0 with phase high drives the stored page value.
- R3: A write with phase high at $D1E2 loads bank bits from data bits 3..0 and the window enable from data bit 4. Data bits 7..5 are dropped. A read returns {3'b000, enable, bank}.
- R4: ram_addr always equals {bank, page, cpu_addr[7:0]}, using the register values in force during that cycle. A register write becomes visible in ram_addr from the next cycle.
- R5: The window claims only addresses $D600 through $D6FF. $D5FF and $D700 are not claimed.
- R6: While the window is disabled, no address is claimed. ram_cs_n, ram_oe_n and ram_we_n stay high, and a window read does not drive the CPU bus.
- R7: An enabled window read asserts ram_cs_n low for the whole cycle. ram_oe_n goes low and cpu_drive goes high only while phase_hi is high, with cpu_rdata equal to ram_rdata, in that same cycle.
- R8: An enabled window write holds ram_cs_n low for the whole cycle. ram_we_n goes low only while phase_hi is high, and ram_oe_n stays high.
- R9: Accesses to addresses outside the two registers and the window, such as $D1E1, change no register. They do not drive the CPU bus, and cpu_rdata reads 0x00 whenever cpu_drive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_hi | input | 1 | High during the data phase of the bus cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read cycle |
| cpu_wr | input | 1 | Write cycle |
| cpu_rdata | output | 8 | Read data toward the CPU |
| cpu_drive | output | 1 | cpu_rdata is valid and should drive the bus |
| win_claim | output | 1 | The current address hits the enabled window |
| ram_addr | output | 20 | Composed RAM address |
| ram_rdata | input | 8 | Data from the RAM |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU bus, 8-bit data, a 256-byte window at $D600, 4 bank bits with the enable at bit 4, and the registers at $D1E0 and $D1E2. With these values every one of the 20 RAM address bits can be set from the bench. The window edges $D600 and $D6FF and their neighbours $D5FF and $D700 can be hit directly. The highest bank (0xF) and a write with the unused data bits 7..5 set can also be exercised.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
    typedef enum logic [0:0] {
        WIN_OFF = 1'b0,
        WIN_ON  = 1'b1
    } win_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PAGE = 2'd1,
        SEL_BANK = 2'd2,
        SEL_WIN  = 2'd3
    } bus_sel_e;
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
    import pgwin_pkg::*;
#(
    parameter int          CPU_AW   = 16,
    parameter int          OFS_BITS = 8,
    parameter logic [15:0] WIN_BASE = 16'hD600,
    parameter logic [15:0] PAGE_REG = 16'hD1E0,
    parameter logic [15:0] BANK_REG = 16'hD1E2
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  win_mode_e         mode,
    output bus_sel_e          sel
);
    localparam int TAG_W = CPU_AW - OFS_BITS;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[CPU_AW-1:OFS_BITS];

    always_comb begin
        if (cpu_addr == PAGE_REG[CPU_AW-1:0])
            sel = SEL_PAGE;
        else if (cpu_addr == BANK_REG[CPU_AW-1:0])
            sel = SEL_BANK;
        else if (mode == WIN_ON && cpu_addr[CPU_AW-1:OFS_BITS] == WIN_TAG)
            sel = SEL_WIN;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/pgwin_regs.sv
module pgwin_regs
    import pgwin_pkg::*;
#(
    parameter int DW        = 8,
    parameter int BANK_BITS = 4,
    parameter int EN_BIT    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_page,
    input  logic                 ld_bank,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        page_q,
    output logic [BANK_BITS-1:0] bank_q,
    output win_mode_e            mode
);
    win_mode_e mode_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            bank_q <= '0;
        end else begin
            if (ld_page) page_q <= wdata;
            if (ld_bank) bank_q <= wdata[BANK_BITS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= WIN_OFF;
        else        mode <= mode_nx;
    end

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            WIN_OFF: if (ld_bank && wdata[EN_BIT])  mode_nx = WIN_ON;
            WIN_ON:  if (ld_bank && !wdata[EN_BIT]) mode_nx = WIN_OFF;
            default: mode_nx = WIN_OFF;
        endcase
    end

    assert_page_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_page |=> page_q == $past(wdata));

    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_bank |=> $stable(bank_q) && $stable(mode));
endmodule

// File: rtl/page_window_ext.sv
module page_window_ext
    import pgwin_pkg::*;
#(
    parameter int          CPU_AW    = 16,
    parameter int          DW        = 8,
    parameter int          OFS_BITS  = 8,
    parameter int          BANK_BITS = 4,
    parameter int          EN_BIT    = 4,
    parameter logic [15:0] WIN_BASE  = 16'hD600,
    parameter logic [15:0] PAGE_REG  = 16'hD1E0,
    parameter logic [15:0] BANK_REG  = 16'hD1E2,
    localparam int         RAM_AW    = BANK_BITS + DW + OFS_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_hi,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_drive,
    output logic              win_claim,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n
);
    bus_sel_e             sel;
    win_mode_e            mode;
    logic [DW-1:0]        page_q;
    logic [BANK_BITS-1:0] bank_q;
    logic [DW-1:0]        bank_rb;
    logic                 wr_phase;
    logic                 rd_phase;

    assign wr_phase = cpu_wr && phase_hi;
    assign rd_phase = cpu_rd && phase_hi;

    pgwin_decode #(
        .CPU_AW(CPU_AW), .OFS_BITS(OFS_BITS), .WIN_BASE(WIN_BASE),
        .PAGE_REG(PAGE_REG), .BANK_REG(BANK_REG)
    ) u_dec (
        .cpu_addr(cpu_addr), .mode(mode), .sel(sel)
    );

    pgwin_regs #(
        .DW(DW), .BANK_BITS(BANK_BITS), .EN_BIT(EN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ld_page(sel == SEL_PAGE && wr_phase),
        .ld_bank(sel == SEL_BANK && wr_phase),
        .wdata(cpu_wdata),
        .page_q(page_q), .bank_q(bank_q), .mode(mode)
    );

    always_comb begin
        bank_rb = '0;
        bank_rb[BANK_BITS-1:0] = bank_q;
        bank_rb[EN_BIT] = (mode == WIN_ON);
    end

    assign ram_addr = {bank_q, page_q, cpu_addr[OFS_BITS-1:0]};

    always_comb begin
        win_claim = 1'b0;
        ram_cs_n  = 1'b1;
        ram_oe_n  = 1'b1;
        ram_we_n  = 1'b1;
        cpu_drive = 1'b0;
        cpu_rdata = '0;
        unique case (sel)
            SEL_NONE: ;
            SEL_PAGE: begin
                cpu_drive = rd_phase;
                if (rd_phase) cpu_rdata = page_q;
            end
            SEL_BANK: begin
                cpu_drive = rd_phase;
                if (rd_phase) cpu_rdata = bank_rb;
            end
            SEL_WIN: begin
                win_claim = 1'b1;
                ram_cs_n  = 1'b0;
                ram_oe_n  = !rd_phase;
                ram_we_n  = !wr_phase;
                cpu_drive = rd_phase;
                if (rd_phase) cpu_rdata = ram_rdata;
            end
            default: ;
        endcase
    end

    assert_we_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> phase_hi && cpu_wr && !ram_cs_n);

    assert_oe_we_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_oe_n && !ram_we_n));

    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode == WIN_OFF |-> ram_cs_n && ram_oe_n && ram_we_n && !win_claim);

    assert_drive_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_drive |-> phase_hi && cpu_rd);
endmodule

// File: tb/sim_page_window_ext.sv
module sim_page_window_ext;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_hi = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_drive;
    logic        win_claim;
    logic [19:0] ram_addr;
    logic [7:0]  ram_rdata = 8'hA5;
    logic        ram_cs_n, ram_oe_n, ram_we_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    page_window_ext u0 (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata), .cpu_drive(cpu_drive), .win_claim(win_claim),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
    );

    // {addr, wdata, rd/wr/ph, claim/cs_n/oe_n/we_n/drive, rdata, ram_addr}
    localparam int NV = 23;
    localparam logic [59:0] VEC [NV] = '{
        {16'hD1E0, 8'h00, 3'b101, 5'b01111, 8'h00, 20'h000E0}, // R2 read after reset
        {16'hD600, 8'h55, 3'b011, 5'b01110, 8'h00, 20'h00000}, // R6 disabled write
        {16'hD1E0, 8'h3C, 3'b011, 5'b01110, 8'h00, 20'h000E0}, // R2 load page
        {16'hD1E2, 8'h17, 3'b011, 5'b01110, 8'h00, 20'h03CE2}, // R3 load bank+enable
        {16'hD1E2, 8'h00, 3'b101, 5'b01111, 8'h17, 20'h73CE2}, // R3 readback
        {16'hD645, 8'h00, 3'b101, 5'b10011, 8'hA5, 20'h73C45}, // R7 read phase high
        {16'hD645, 8'h00, 3'b100, 5'b10110, 8'h00, 20'h73C45}, // R7 read phase low
        {16'hD6FF, 8'h11, 3'b011, 5'b10100, 8'h00, 20'h73CFF}, // R8 top edge write
        {16'hD6FF, 8'h11, 3'b010, 5'b10110, 8'h00, 20'h73CFF}, // R8 phase low
        {16'hD5FF, 8'h00, 3'b101, 5'b01110, 8'h00, 20'h73CFF}, // R5 below window
        {16'hD700, 8'h00, 3'b101, 5'b01110, 8'h00, 20'h73C00}, // R5 above window
        {16'hD1E0, 8'h81, 3'b011, 5'b01110, 8'h00, 20'h73CE0}, // R4 page change
        {16'hD600, 8'h66, 3'b011, 5'b10100, 8'h00, 20'h78100}, // R4 new page, base edge
        {16'hD1E2, 8'hEF, 3'b011, 5'b01110, 8'h00, 20'h781E2}, // R3 disable, top bits set
        {16'hD1E2, 8'h00, 3'b101, 5'b01111, 8'h0F, 20'hF81E2}, // R3 bits 7..5 dropped
        {16'hD680, 8'h00, 3'b101, 5'b01110, 8'h00, 20'hF8180}, // R6 disabled read
        {16'hD1E1, 8'hFF, 3'b011, 5'b01110, 8'h00, 20'hF81E1}, // R9 stray write
        {16'hD1E0, 8'h00, 3'b101, 5'b01111, 8'h81, 20'hF81E0}, // R9 page untouched
        {16'hD1E1, 8'h00, 3'b101, 5'b01110, 8'h00, 20'hF81E1}, // R9 no drive
        {16'hD1E0, 8'h22, 3'b010, 5'b01110, 8'h00, 20'hF81E0}, // R2 phase-low write
        {16'hD1E0, 8'h00, 3'b101, 5'b01111, 8'h81, 20'hF81E0}, // R2 ignored
        {16'hD1E2, 8'h10, 3'b011, 5'b01110, 8'h00, 20'hF81E2}, // R3 bank 0 enabled
        {16'hD6AB, 8'h00, 3'b101, 5'b10011, 8'hA5, 20'h081AB}  // R4 composed address
    };

    function automatic string vtag(int i);
        case (i)
            0, 2, 19, 20:   return "R2";
            3, 4, 13, 14, 21: return "R3";
            11, 12, 22:     return "R4";
            9, 10:          return "R5";
            1, 15:          return "R6";
            5, 6:           return "R7";
            7, 8:           return "R8";
            default:        return "R9";
        endcase
    endfunction

    task automatic drive(input logic [15:0] a, input logic [7:0] d,
                         input logic rd, input logic wr, input logic ph);
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr; phase_hi = ph;
    endtask

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] outs();
        return {win_claim, ram_cs_n, ram_oe_n, ram_we_n, cpu_drive, cpu_rdata, ram_addr};
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state seen at the ports
        drive(16'hD1E2, 8'h00, 1'b1, 1'b0, 1'b1);
        #2;
        check("R1", outs(), {5'b01111, 8'h00, 20'h000E2});
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][59:44], VEC[i][43:36], VEC[i][35], VEC[i][34], VEC[i][33]);
            #2;
            check(vtag(i), outs(), VEC[i][32:0]);
        end
        // R1: reset in mid-run clears both registers and disables the window
        @(negedge clk);
        rst_n = 1'b0;
        drive(16'hD645, 8'h00, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1", outs(), {5'b01110, 8'h00, 20'h00045});
        @(negedge clk);
        drive(16'hD1E2, 8'h00, 1'b1, 1'b0, 1'b1);
        #2;
        check("R1", outs(), {5'b01111, 8'h00, 20'h000E2});
        @(negedge clk);
        drive(16'hD1E0, 8'h00, 1'b1, 1'b0, 1'b1);
        #2;
        check("R1", outs(), {5'b01111, 8'h00, 20'h000E0});
        @(negedge clk);
        drive(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule